// File: doc/BRIEF.md
# Multi-Channel ADC Scan Controller

This block is the digital control engine that sits in front of a multi-channel analog-to-digital converter. It holds one 32-bit control word that software writes and reads through a plain register port. The word carries the engine enable, a 3-bit operating mode, a reference selection, a compensation-sensing switch, two battery-sensing controls and one enable bit per channel. The engine starts converting only when it is enabled, in normal mode, and its hardware ready flag is set. The ready flag sets a fixed number of clocks after normal mode is entered with the engine enabled.

When the engine is running, each pulse on the sample strobe starts one conversion. The conversion goes to the next enabled channel in ascending order after the channel converted last, wrapping from the top channel back to the bottom one. The conversion is handed to the converter through a request/acknowledge handshake. The returned 10-bit code is stored in that channel's 16-bit result slot. Result slots are packed two to a 32-bit word, so software reads them as half-words.

Top module: `adc_scan_engine`

## Requirements
- R1: The control word keeps only these written bits: 0 (engine enable), 3:1 (mode), 4 (compensation sensing), 7:6 (reference select), 12 (channel-7 battery mode), 13 (battery sensing) and 31:16 (per-channel enables, bit 16+n for channel n). Every other bit reads 0. Writes cannot change bit 8.
- R2: After reset, the control word reads 0, all result words read 0 and no conversion request is raised.
- R3: Bit 8 (ready) reads 1 exactly INIT_CYCLES clock edges after the edge that writes enable=1 and mode=7. It stays 0 while the engine is disabled.
- R4: Mode 0 (power-down) clears ready on the edge that writes that mode. Returning to normal mode restarts the full INIT_CYCLES wait before any conversion can start.
- R5: A sample strobe starts a conversion only when enable=1, mode=7 and ready=1. Otherwise it has no effect and no request is raised.
- R6: Channels are converted in ascending order, starting after the channel converted last and wrapping around. Disabled channels are skipped. The first conversion after reset goes to the lowest enabled channel.
- R7: A request stays high with a stable channel number until acknowledged. A sample strobe that arrives while a request is pending is ignored.
- R8: An acknowledged 10-bit code is stored zero-extended in a 16-bit slot at byte offset 0x10+2n. Even channels occupy bits 15:0 and odd channels bits 31:16 of the word at 0x10+4*(n/2).
- R9: Offsets that are not word-aligned, offsets above 0xD0, and aligned offsets without a register all read 0. Writes to any offset other than 0x00, including the result words, change nothing.
- R10: A control write in the same cycle as an acknowledge still stores the result, even if that write disables the channel. The next pick uses the newly written enables and starts after the channel just completed.
- R11: Mode 1 (standby) keeps the ready flag but ignores strobes. Returning to mode 7 allows conversions again at once, with no new wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sample_stb | input | 1 | Sample strobe, one conversion per pulse |
| conv_req | output | 1 | Conversion request to the converter |
| conv_ch | output | $clog2(NUM_CH) | Channel of the pending request |
| conv_ack | input | 1 | Converter acknowledge with valid code |
| conv_data | input | RES_W | Converted code |

## Verification
The converter's acknowledge and a software write to the control word can land on the same clock edge. That write may clear the enable of the very channel being converted. The bench provokes this by raising conv_ack and reg_wen in the same cycle, with a write that drops the pending channel and enables a set whose first member lies below it. The result is judged correct when the code appears in the dropped channel's slot, the control word reads back the new enables with ready still set, and the next strobe goes to the lowest newly enabled channel. That last point shows the round-robin position moved to the completed channel and the pick used the new enables.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   // register map byte offsets
   localparam int unsigned CTRL_OFS   = 32'h00;
   localparam int unsigned DATA_BASE  = 32'h10;
   localparam int unsigned REG_LIMIT  = 32'hD0;

   // operating mode encodings
   localparam logic [2:0] MODE_PWR_DOWN = 3'd0;
   localparam logic [2:0] MODE_STANDBY  = 3'd1;
   localparam logic [2:0] MODE_NORMAL   = 3'd7;

   // bits software may set in the control word
   localparam logic [31:0] CTRL_WMASK = 32'hFFFF_30DF;

   typedef struct packed {
      logic [15:0] ch_en;
      logic [1:0]  rsv_15_14;
      logic        bat_sense;
      logic        ch7_bat;
      logic [2:0]  rsv_11_9;
      logic        init_rdy;
      logic [1:0]  vref_sel;
      logic        rsv_5;
      logic        comp_sense;
      logic [2:0]  mode;
      logic        enable;
   } ctrl_word_t;

endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
   import adc_scan_pkg::*;
#(
   parameter int unsigned NUM_CH      = 16,
   parameter int unsigned INIT_CYCLES = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [31:0] wr_data,
   output ctrl_word_t ctrl_q,
   output logic       scan_ok
);
   localparam int unsigned CNT_W   = $clog2(INIT_CYCLES + 1);
   localparam logic [15:0] CH_MASK = 16'((33'h1 << NUM_CH) - 33'h1);

   ctrl_word_t       nxt;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             warm;

   assign warm    = ctrl_q.enable && (ctrl_q.mode == MODE_NORMAL);
   assign scan_ok = warm && ctrl_q.init_rdy;

   always_comb begin
      nxt = ctrl_q;
      if (wr_en) begin
         nxt       = ctrl_word_t'(wr_data & CTRL_WMASK);
         nxt.ch_en = nxt.ch_en & CH_MASK;
      end
      // ready flag is owned by hardware only
      if (nxt.mode == MODE_PWR_DOWN)
         nxt.init_rdy = 1'b0;
      else if (warm && !ctrl_q.init_rdy && cnt_q == CNT_W'(INIT_CYCLES - 1))
         nxt.init_rdy = 1'b1;
      else
         nxt.init_rdy = ctrl_q.init_rdy;

      if (!warm || ctrl_q.init_rdy || nxt.mode == MODE_PWR_DOWN)
         cnt_d = '0;
      else
         cnt_d = cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cnt_q  <= '0;
      end else begin
         ctrl_q <= nxt;
         cnt_q  <= cnt_d;
      end
   end
endmodule

// File: rtl/adc_chan_sched.sv
module adc_chan_sched #(
   parameter int unsigned NUM_CH = 16,
   localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_ok,
   input  logic [NUM_CH-1:0] ch_en,
   input  logic              sample_stb,
   input  logic              conv_ack,
   output logic              conv_req,
   output logic [CH_W-1:0]   conv_ch,
   output logic              done,
   output logic [CH_W-1:0]   done_ch
);
   logic [CH_W-1:0] last_q, cur_q, pick;
   logic            busy_q, found, launch;

   // next enabled channel strictly after last_q, wrapping
   always_comb begin
      found = 1'b0;
      pick  = last_q;
      for (int i = 1; i <= int'(NUM_CH); i++) begin
         int idx;
         idx = (int'(last_q) + i) % int'(NUM_CH);
         if (!found && ch_en[idx]) begin
            found = 1'b1;
            pick  = CH_W'(idx);
         end
      end
   end

   assign launch   = sample_stb && scan_ok && !busy_q && found;
   assign conv_req = busy_q;
   assign conv_ch  = cur_q;
   assign done     = busy_q && conv_ack;
   assign done_ch  = cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cur_q  <= '0;
         last_q <= CH_W'(NUM_CH - 1);
      end else if (launch) begin
         busy_q <= 1'b1;
         cur_q  <= pick;
      end else if (done) begin
         busy_q <= 1'b0;
         last_q <= cur_q;
      end
   end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int unsigned NUM_CH = 16,
   parameter int unsigned RES_W  = 10,
   localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_valid,
   input  logic [CH_W-1:0]        wr_ch,
   input  logic [RES_W-1:0]       wr_data,
   output logic [NUM_CH-1:0][15:0] slot
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[c] <= '0;
         else if (wr_valid && wr_ch == CH_W'(c))
            slot[c] <= 16'(wr_data);
      end
   end
endmodule

// File: rtl/adc_scan_engine.sv
module adc_scan_engine
   import adc_scan_pkg::*;
#(
   parameter int unsigned NUM_CH      = 16,
   parameter int unsigned RES_W       = 10,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned INIT_CYCLES = 8,
   localparam int unsigned CH_W       = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wen,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              sample_stb,
   output logic              conv_req,
   output logic [CH_W-1:0]   conv_ch,
   input  logic              conv_ack,
   input  logic [RES_W-1:0]  conv_data
);
   localparam int unsigned NWORDS = (NUM_CH + 1) / 2;

   if (NUM_CH < 2 || NUM_CH > 16) begin : g_bad_ch
      $error("NUM_CH must lie in 2..16");
   end
   if (RES_W < 1 || RES_W > 16) begin : g_bad_res
      $error("RES_W must lie in 1..16");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end
   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("INIT_CYCLES must be at least 1");
   end

   ctrl_word_t              ctrl_q;
   logic                    scan_ok, ctrl_wr, done;
   logic [CH_W-1:0]         done_ch;
   logic [NUM_CH-1:0][15:0] slot;
   logic [NWORDS-1:0][31:0] data_words;
   logic [ADDR_W-1:0]       rel;

   assign ctrl_wr = reg_wen && (reg_addr == ADDR_W'(CTRL_OFS));

   adc_ctrl_reg #(.NUM_CH(NUM_CH), .INIT_CYCLES(INIT_CYCLES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wr_data(reg_wdata),
      .ctrl_q(ctrl_q), .scan_ok(scan_ok)
   );

   adc_chan_sched #(.NUM_CH(NUM_CH)) u_sched (
      .clk(clk), .rst_n(rst_n), .scan_ok(scan_ok),
      .ch_en(ctrl_q.ch_en[NUM_CH-1:0]), .sample_stb(sample_stb),
      .conv_ack(conv_ack), .conv_req(conv_req), .conv_ch(conv_ch),
      .done(done), .done_ch(done_ch)
   );

   adc_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_valid(done), .wr_ch(done_ch),
      .wr_data(conv_data), .slot(slot)
   );

   // pack two slots per word; a missing odd slot reads zero
   for (genvar k = 0; k < NWORDS; k++) begin : g_word
      if (2 * k + 1 < NUM_CH) begin : g_pair
         assign data_words[k] = {slot[2*k+1], slot[2*k]};
      end else begin : g_single
         assign data_words[k] = {16'h0000, slot[2*k]};
      end
   end

   assign rel = reg_addr - ADDR_W'(DATA_BASE);

   always_comb begin
      reg_rdata = '0;
      if (reg_addr[1:0] == 2'b00 && reg_addr <= ADDR_W'(REG_LIMIT)) begin
         if (reg_addr == ADDR_W'(CTRL_OFS)) begin
            reg_rdata = ctrl_q;
         end else if (reg_addr >= ADDR_W'(DATA_BASE)) begin
            for (int k = 0; k < int'(NWORDS); k++)
               if (int'(rel[ADDR_W-1:2]) == k) reg_rdata = data_words[k];
         end
      end
   end
endmodule

// File: rtl/adc_scan_engine_chk.sv
module adc_scan_engine_chk #(
   parameter int unsigned NUM_CH = 16,
   localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            conv_req,
   input logic [CH_W-1:0] conv_ch,
   input logic            conv_ack,
   input logic            sample_stb,
   input logic [31:0]     ctrl_bits,
   input logic            scan_ok
);
   assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_ack) |=> (conv_req && $stable(conv_ch)));

   assert_launch_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_req) |-> $past(scan_ok && sample_stb));

   assert_launch_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_req) |->
         ((($past(ctrl_bits) >> (32'd16 + 32'(conv_ch))) & 32'd1) == 32'd1));

   assert_pd_clears_rdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_bits[3:1] == 3'd0) |-> !ctrl_bits[8]);

   assert_rdy_needs_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_bits[8]) |-> $past(ctrl_bits[0] && ctrl_bits[3:1] == 3'd7));
endmodule

bind adc_scan_engine adc_scan_engine_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_ch(conv_ch),
   .conv_ack(conv_ack), .sample_stb(sample_stb), .ctrl_bits(ctrl_q),
   .scan_ok(scan_ok)
);

// File: tb/tb_adc_scan_engine.sv
module tb_adc_scan_engine;
   localparam int NUM_CH = 16;
   localparam int INIT   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wen = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sample_stb = 1'b0;
   logic        conv_req;
   logic [3:0]  conv_ch;
   logic        conv_ack = 1'b0;
   logic [9:0]  conv_data = '0;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   adc_scan_engine #(.NUM_CH(NUM_CH), .INIT_CYCLES(INIT)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sample_stb(sample_stb),
      .conv_req(conv_req), .conv_ch(conv_ch), .conv_ack(conv_ack),
      .conv_data(conv_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic strobe();
      @(negedge clk) sample_stb = 1'b1;
      @(negedge clk) sample_stb = 1'b0;
   endtask

   task automatic expect_idle(input string tag);
      strobe();
      for (int i = 0; i < 3; i++) begin
         chk(tag, {31'd0, conv_req}, 32'd0);
         @(negedge clk);
      end
   endtask

   task automatic run_conv(input int ch, input logic [9:0] d, input int lat, input string tag);
      logic [31:0] w;
      strobe();
      chk({tag, " req"}, {31'd0, conv_req}, 32'd1);
      chk({tag, " ch"}, 32'(conv_ch), 32'(ch));
      for (int i = 0; i < lat; i++) begin
         sample_stb = 1'b1;
         @(negedge clk);
         sample_stb = 1'b0;
         chk({tag, " R7 hold"}, {27'd0, conv_req, conv_ch}, {27'd0, 1'b1, 4'(ch)});
      end
      conv_ack = 1'b1; conv_data = d;
      @(negedge clk);
      conv_ack = 1'b0;
      chk({tag, " R7 drop"}, {31'd0, conv_req}, 32'd0);
      rd(8'(8'h10 + 4 * (ch / 2)), w);
      chk({tag, " R8 slot"}, (ch % 2 == 1) ? {16'd0, w[31:16]} : {16'd0, w[15:0]}, {22'd0, d});
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h00, v); chk("R2 ctrl", v, 32'h0);
      rd(8'h10, v); chk("R2 data", v, 32'h0);
      chk("R2 req", {31'd0, conv_req}, 32'd0);
   endtask

   task automatic t_fields();
      logic [31:0] v;
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, v); chk("R1 mask", v, 32'hFFFF_30DF);
      wr(8'h00, 32'h0);
      rd(8'h00, v); chk("R1 clear", v, 32'h0);
   endtask

   task automatic t_disabled();
      logic [31:0] v;
      wr(8'h00, 32'h0001_000E);
      repeat (20) @(negedge clk);
      rd(8'h00, v); chk("R3 no rdy when disabled", v, 32'h0001_000E);
      expect_idle("R5 disabled");
   endtask

   task automatic t_init();
      logic [31:0] v;
      wr(8'h00, 32'h0001_000F);
      repeat (INIT - 1) @(negedge clk);
      rd(8'h00, v); chk("R3 not yet", {31'd0, v[8]}, 32'd0);
      @(negedge clk);
      rd(8'h00, v); chk("R3 ready", v, 32'h0001_010F);
   endtask

   task automatic t_standby();
      logic [31:0] v;
      wr(8'h00, 32'h0001_0003);
      rd(8'h00, v); chk("R11 rdy kept", v, 32'h0001_0103);
      expect_idle("R11 standby");
      wr(8'h00, 32'h0001_000F);
      rd(8'h00, v); chk("R11 back", v, 32'h0001_010F);
      run_conv(0, 10'h155, 2, "R11");
   endtask

   task automatic t_rr();
      logic [31:0] v;
      wr(8'h00, 32'h8012_000F);
      run_conv(1, 10'h3FF, 0, "R6 a");
      run_conv(4, 10'h001, 1, "R6 b");
      run_conv(15, 10'h2AA, 3, "R6 c");
      run_conv(1, 10'h123, 0, "R6 wrap");
      rd(8'h10, v); chk("R8 pair", v, 32'h0123_0155);
      rd(8'h2C, v); chk("R8 top", v, 32'h02AA_0000);
   endtask

   task automatic t_decode();
      logic [31:0] v;
      rd(8'h12, v); chk("R9 unaligned", v, 32'h0);
      rd(8'hD4, v); chk("R9 above", v, 32'h0);
      rd(8'h30, v); chk("R9 hole", v, 32'h0);
      rd(8'hD0, v); chk("R9 last", v, 32'h0);
      wr(8'h10, 32'hDEAD_BEEF);
      rd(8'h10, v); chk("R9 data ro", v, 32'h0123_0155);
      wr(8'h01, 32'h0);
      rd(8'h00, v); chk("R9 alias", v, 32'h8012_010F);
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, v); chk("R9 hole wr", v, 32'h0);
   endtask

   task automatic t_collide();
      logic [31:0] v;
      strobe();
      chk("R10 pick", {27'd0, conv_req, conv_ch}, {27'd0, 1'b1, 4'd4});
      reg_wen = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h0006_000F;
      conv_ack = 1'b1; conv_data = 10'h0AB;
      @(negedge clk);
      reg_wen = 1'b0; conv_ack = 1'b0;
      rd(8'h18, v); chk("R10 stored", v, 32'h0000_00AB);
      rd(8'h00, v); chk("R10 ctrl", v, 32'h0006_010F);
      run_conv(1, 10'h0F0, 0, "R10 next");
   endtask

   task automatic t_powerdown();
      logic [31:0] v;
      wr(8'h00, 32'h0006_0001);
      rd(8'h00, v); chk("R4 cleared", v, 32'h0006_0001);
      wr(8'h00, 32'h0006_000F);
      expect_idle("R4 wait");
      repeat (INIT) @(negedge clk);
      rd(8'h00, v); chk("R4 rdy again", v, 32'h0006_010F);
      run_conv(2, 10'h2FF, 1, "R4 conv");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fields();
      t_disabled();
      t_init();
      t_standby();
      t_rr();
      t_decode();
      t_collide();
      t_powerdown();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule